// File: doc/BRIEF.md
# Addressable Eight-Bit Latch Demultiplexer

This block is an eight-bit storage register with a single serial data input. A three-bit address picks one of the eight bits to be updated from that input. It can therefore write bits at random, load a byte one bit at a time, or act as a one-of-eight decoder. The block is a synchronous model with a sampling clock. Two active-low control lines choose the operating mode on every clock edge:

| Control lines | Mode | Effect |
|---|---|---|
| clear low, enable high | clear | every bit goes to zero |
| clear low, enable low | demultiplex | the addressed bit takes the data input and every other bit goes to zero |
| clear high, enable low | addressable write | the addressed bit takes the data input and every other bit keeps its value |
| clear high, enable high | store | all bits hold |

All eight stored bits drive the parallel output at all times. A bit holds the data value it received at the last edge on which it was addressed or cleared. A write sequence therefore keeps the data value sampled at the last edge before the enable goes high. Software or a controller should change the address only while the enable is high.

Top module: `addr_latch_demux`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `q` becomes all zero after that edge.
- R2: Addressable write mode is `clr_n`=1 and `en_n`=0. After a rising edge in this mode, `q[addr]` equals the `din` value at that edge, and every other bit of `q` is unchanged.
- R3: Store mode is `clr_n`=1 and `en_n`=1. After a rising edge in this mode, all of `q` is unchanged, whatever the values of `din` and `addr`.
- R4: Demultiplex mode is `clr_n`=0 and `en_n`=0. After a rising edge in this mode, `q[addr]` equals `din` and every other bit is zero. With `din`=1, `q` is the one-hot decode of `addr`.
- R5: Clear mode is `clr_n`=0 and `en_n`=1. After a rising edge in this mode, `q` is all zero, whatever the values of `din` and `addr`.
- R6: `addr` is read as an unsigned binary number with `addr[0]` as the least significant bit. The value N selects output bit `q[N]`.
- R7: Suppose `en_n` stays low for several edges with a fixed address while `din` changes, and `en_n` then rises. The addressed bit then keeps the `din` value that was sampled at the last edge with `en_n` low.
- R8: A pattern produced by a demultiplex-mode edge or by a series of writes is kept exactly through any number of following store-mode edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the stored bits |
| din | input | 1 | Serial data bit written to the addressed position |
| addr | input | ADDR_W (3) | Binary index of the selected bit |
| en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear control |
| q | output | 2**ADDR_W (8) | Stored bits, one per address |

## Verification
The bench tests every combination of mode, address and data value. Before each one it preloads a different background pattern, so that each bit is seen both changing and holding. A design that got the address decode wrong, for example with reversed bit order or an off-by-one index, would write the wrong output bit. A design that mixed up the two modes with enable low would either clear the neighbours of the addressed bit during an addressable write, or leave stale bits set during a demultiplex edge. The bench also changes the data input across a run of write edges, to catch a model that keeps the first sample instead of the last. It holds store mode after a decode to catch any leakage of the data input or the address into bits that should hold.

// File: rtl/addr_latch_demux_pkg.sv
// Package: shared mode type for the addressable latch demultiplexer.
// Assumes: the two active-low controls map one-to-one onto four modes.
package addr_latch_demux_pkg;

    typedef enum logic [1:0] {
        MODE_STORE = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_DEMUX = 2'b11
    } alm_mode_e;

endpackage

// File: rtl/alm_mode_dec.sv
// Module: alm_mode_dec
// Turns the active-low clear and enable controls into one mode code.
// Assumes: both controls are synchronous to the sampling clock.
module alm_mode_dec
    import addr_latch_demux_pkg::*;
(
    input  logic      clr_n,
    input  logic      en_n,
    output alm_mode_e mode
);

    // Map the control pair onto a mode.
    always_comb begin
        unique case ({clr_n, en_n})
            2'b11:   mode = MODE_STORE;
            2'b10:   mode = MODE_WRITE;
            2'b01:   mode = MODE_CLEAR;
            default: mode = MODE_DEMUX;
        endcase
    end

endmodule

// File: rtl/alm_addr_dec.sv
// Module: alm_addr_dec
// Binary-to-one-hot decoder; addr[0] is the least significant bit.
// Assumes: WIDTH equals 2**ADDR_W so every code selects exactly one line.
module alm_addr_dec #(
    parameter int ADDR_W = 3,
    localparam int WIDTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WIDTH-1:0]  sel
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_line
            localparam logic [ADDR_W-1:0] IDX = ADDR_W'(gi);
            // Raise line gi when the address equals its index.
            always_comb sel[gi] = (addr == IDX);
        end
    endgenerate

endmodule

// File: rtl/alm_bit_cell.sv
// Module: alm_bit_cell
// One storage bit. It decides from the mode and its select line whether to
// load din, hold, or drop to zero.
// Assumes: synchronous active-low reset; sel is one-hot across all cells.
module alm_bit_cell
    import addr_latch_demux_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  alm_mode_e mode,
    input  logic      sel,
    input  logic      din,
    output logic      bit_q
);

    logic nxt;

    // Compute the next value of this bit for the current mode.
    always_comb begin
        unique case (mode)
            MODE_WRITE: nxt = sel ? din : bit_q;
            MODE_DEMUX: nxt = sel & din;
            MODE_CLEAR: nxt = 1'b0;
            default:    nxt = bit_q;
        endcase
    end

    // Register the bit, clearing it on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= nxt;
    end

endmodule

// File: rtl/addr_latch_demux.sv
// Module: addr_latch_demux (top)
// Eight-bit addressable latch with decode mode, built as a clocked model.
// It contains a mode decoder, an address decoder and one cell per bit.
// Assumes: addr changes only while en_n is high; all inputs sync to clk.
module addr_latch_demux
    import addr_latch_demux_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int WIDTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_n,
    input  logic              clr_n,
    output logic [WIDTH-1:0]  q
);

    alm_mode_e        mode;
    logic [WIDTH-1:0] sel;

    alm_mode_dec u_mode (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    alm_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
        .addr (addr),
        .sel  (sel)
    );

    genvar gb;
    generate
        for (gb = 0; gb < WIDTH; gb++) begin : g_bit
            alm_bit_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .mode  (mode),
                .sel   (sel[gb]),
                .din   (din),
                .bit_q (q[gb])
            );
        end
    endgenerate

endmodule

// File: rtl/addr_latch_demux_chk.sv
// Module: addr_latch_demux_chk
// Port-level temporal checks of the latch, attached to the top by bind.
// Assumes: it is sampled on the same clock edge as the design.
module addr_latch_demux_chk #(
    parameter int ADDR_W = 3,
    localparam int WIDTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              din,
    input logic [ADDR_W-1:0] addr,
    input logic              en_n,
    input logic              clr_n,
    input logic [WIDTH-1:0]  q
);

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R1

    AST_WRITE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !en_n) |=> (q[$past(addr)] == $past(din))); // R2

    AST_WRITE_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !en_n) |=>
        (((q ^ $past(q)) & ~(WIDTH'(1) << $past(addr))) == '0)); // R2

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && en_n) |=> $stable(q)); // R3

    AST_DEMUX_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !en_n) |=>
        ($onehot0(q) && (q[$past(addr)] == $past(din)))); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && en_n) |=> (q == '0)); // R5

endmodule

bind addr_latch_demux addr_latch_demux_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .addr  (addr),
    .en_n  (en_n),
    .clr_n (clr_n),
    .q     (q)
);

// File: tb/addr_latch_demux_tb.sv
`timescale 1ns/1ps
// Bench for addr_latch_demux. It sweeps every mode, address and data value
// and computes the expected output from the mode rules.
module addr_latch_demux_tb;

    localparam int ADDR_W = 3;
    localparam int WIDTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              din = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              en_n = 1'b1;
    logic              clr_n = 1'b1;
    logic [WIDTH-1:0]  q;
    logic [WIDTH-1:0]  model = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    addr_latch_demux #(.ADDR_W(ADDR_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .din (din), .addr (addr),
        .en_n (en_n), .clr_n (clr_n), .q (q)
    );

    always #2 clk = ~clk;

    // Watchdog: count cycles and stop a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog q=%h expected %h", q, model);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req);
        checks++;
        if (q !== model) begin
            errors++;
            $display("FAIL %s q=%h expected %h", req, q, model);
        end
    endtask

    // Apply one clock edge with the given inputs and update the model.
    task automatic step(input logic d, input int a, input logic e_n, input logic c_n);
        @(negedge clk);
        din = d; addr = ADDR_W'(a); en_n = e_n; clr_n = c_n;
        case ({c_n, e_n})
            2'b10: model[a] = d;
            2'b01: model = '0;
            2'b00: model = d ? (WIDTH'(1) << a) : '0;
            default: ;
        endcase
        @(posedge clk);
        #1;
    endtask

    task automatic preload(input logic [WIDTH-1:0] pat);
        for (int i = 0; i < WIDTH; i++) step(pat[i], i, 1'b0, 1'b1);
        check("R2 preload");
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        model = '0;
        check("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep over mode x address x data with varied backgrounds.
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < WIDTH; a++) begin
                for (int d = 0; d < 2; d++) begin
                    logic [WIDTH-1:0] pat;
                    logic c_n, e_n;
                    pat = WIDTH'((a * 37 + m * 91 + d * 150) ^ 8'h5A);
                    preload(pat);
                    c_n = m[1];
                    e_n = m[0];
                    step(d[0], a, e_n, c_n);
                    case (m)
                        0: check("R4 demux");
                        1: check("R5 clear");
                        2: check("R2 R6 write");
                        default: check("R3 store");
                    endcase
                end
            end
        end

        // R6: decode with din high gives the one-hot code of each address.
        for (int a = 0; a < WIDTH; a++) begin
            step(1'b1, a, 1'b0, 1'b0);
            if (q !== (WIDTH'(1) << a)) begin
                errors++;
                $display("FAIL R6 q=%h expected %h", q, WIDTH'(1) << a);
            end
            checks++;
        end

        // R7: din toggles across several write edges; the last sample is kept.
        preload(8'h00);
        step(1'b1, 5, 1'b0, 1'b1);
        step(1'b0, 5, 1'b0, 1'b1);
        step(1'b1, 5, 1'b0, 1'b1);
        step(1'b0, 5, 1'b1, 1'b1);
        check("R7 last sample kept");
        preload(8'hFF);
        step(1'b0, 2, 1'b0, 1'b1);
        step(1'b1, 2, 1'b0, 1'b1);
        step(1'b0, 2, 1'b0, 1'b1);
        step(1'b1, 2, 1'b1, 1'b1);
        check("R7 last sample kept");

        // R8: decode result survives store edges with noisy din and addr.
        step(1'b1, 6, 1'b0, 1'b0);
        for (int k = 0; k < 10; k++) begin
            step(k[0], (k * 3) % WIDTH, 1'b1, 1'b1);
            check("R8 hold after demux");
        end
        preload(8'hC3);
        for (int k = 0; k < 6; k++) begin
            step(~k[0], k, 1'b1, 1'b1);
            check("R8 hold after writes");
        end

        // R1: reset in the middle of operation clears a nonzero pattern.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        model = '0;
        check("R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule